// File: doc/BRIEF.md
# Decode-Stage Branch Redirect Unit

This unit sits between instruction decode and rename. Each cycle it takes a group of up to `W` decoded instructions, held in slots in program order with slot 0 the oldest. It finds the prediction errors that can be settled without executing anything. There are two kinds: a non-control instruction that the front end predicted taken, and a direct branch whose predicted target differs from its real target. The real target is PC plus the sign-extended immediate offset. Indirect branches are passed through unchecked.

Only the oldest error in a group counts. The offending instruction is still forwarded, with its predicted target replaced by the corrected next PC. Every slot behind it is dropped in the same cycle. A redirect packet goes to fetch one cycle later. It carries the offender's sequence number, the corrected next PC and a taken flag. The unit then enters a flush window of `FLUSH_CYC` cycles. In that window any arriving instruction with a larger sequence number than the offender is discarded. When the window closes, the unit sends a one-cycle unblock pulse to fetch. Three counters track branches resolved here, target mispredictions and false-branch mispredictions.

The controller has two states. `ST_RUN` is normal operation. `ST_FLUSH` is the flush window. The transitions are:
- `ST_RUN` to `ST_FLUSH` when a group yields a redirect.
- `ST_FLUSH` to `ST_FLUSH` when an older instruction yields another redirect, which reloads the window.
- `ST_FLUSH` to `ST_RUN` when the window count runs out, which raises unblock.

Top module: `dec_redirect`

## Requirements
- R1: After reset every output is 0, including all three counters, and the unit is in `ST_RUN`.
- R2: A slot whose squashed flag is 1 is never forwarded and never raises a redirect.
- R3: A slot predicted taken with its control flag 0 is a false-branch error. Its redirect has next PC = PC + `INST_BYTES` (4) and taken = 0. It increments `cnt_ctrl_mispred`.
- R4: A slot with control = 1, direct = 1 and (unconditional = 1 or predicted taken = 1) has target = PC + sign-extended `in_imm` compared with its predicted target. On a mismatch the redirect carries next PC = that target and taken = 1, and `cnt_mispred` increments. On a match no redirect is raised.
- R5: A control slot with direct = 0 is never checked, whatever its predicted target.
- R6: Only the lowest-numbered erring slot of a group makes a redirect. That slot is forwarded with `out_ptarg` set to the corrected next PC. All higher-numbered slots of the group are dropped.
- R7: Forwarded slots and the redirect packet (`rd_valid`, `rd_seq`, `rd_npc`, `rd_taken`) appear on the cycle after the group is presented. `rd_seq` is the offender's sequence number.
- R8: For `FLUSH_CYC` cycles after a redirect, an arriving slot with a sequence number greater than the offender's is dropped. Slots with a smaller or equal number are handled normally.
- R9: `unblock` is 1 for exactly one cycle, on the cycle after the last flush-window cycle.
- R10: `cnt_resolved` increases by the number of forwarded slots that were target-checked under R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | W | Slot holds an instruction |
| in_squashed | input | W | Slot already squashed |
| in_ctrl | input | W | Slot is a control instruction |
| in_direct | input | W | Slot is PC-relative |
| in_uncond | input | W | Slot is unconditional |
| in_ptaken | input | W | Predicted taken |
| in_seq | input | W*SEQ_W | Sequence numbers |
| in_pc | input | W*PC_W | Instruction addresses |
| in_ptarg | input | W*PC_W | Predicted targets |
| in_imm | input | W*IMM_W | Signed branch offsets |
| out_valid | output | W | Forwarded slot mask |
| out_seq | output | W*SEQ_W | Forwarded sequence numbers |
| out_pc | output | W*PC_W | Forwarded addresses |
| out_ptarg | output | W*PC_W | Forwarded, corrected predicted targets |
| rd_valid | output | 1 | Redirect: mispredict and squash to fetch |
| rd_seq | output | SEQ_W | Offending sequence number |
| rd_npc | output | PC_W | Corrected next PC |
| rd_taken | output | 1 | Corrected direction |
| unblock | output | 1 | Flush window closed |
| cnt_resolved | output | CNT_W | Branches resolved at decode |
| cnt_mispred | output | CNT_W | Target mispredictions |
| cnt_ctrl_mispred | output | CNT_W | False-branch mispredictions |

## Verification
Forwarded slots, the redirect packet and all three counters are registered once, so they are due on the first rising edge after a group is driven. The bench drives on the falling edge and reads one full period later, at the next falling edge. The unblock pulse is due `FLUSH_CYC` edges after the redirect edge. With the default of 1, the bench inserts one idle group after each redirect-bearing vector and reads unblock at the falling edge after that idle group. The flush-window test drives its second group on the cycle directly after the redirect group, so that group falls inside the window.

// File: rtl/dec_redirect_pkg.sv
package dec_redirect_pkg;
    typedef enum logic [0:0] {ST_RUN, ST_FLUSH} rd_state_e;
    typedef enum logic [1:0] {MK_NONE, MK_FALSE_BR, MK_TARGET} miss_kind_e;
endpackage

// File: rtl/dec_slot_check.sv
module dec_slot_check
    import dec_redirect_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int IMM_W      = 12,
    parameter int INST_BYTES = 4
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    input  logic             ctrl,
    input  logic             direct,
    input  logic             uncond,
    input  logic             ptaken,
    input  logic [PC_W-1:0]  ptarg,
    output logic             checked,
    output miss_kind_e       kind,
    output logic [PC_W-1:0]  fix_pc
);
    localparam int EXT_W = PC_W - IMM_W;
    logic [PC_W-1:0] target;

    always_comb begin
        target  = pc + {{EXT_W{imm[IMM_W-1]}}, imm};
        checked = ctrl & direct & (uncond | ptaken);
        kind    = MK_NONE;
        fix_pc  = ptarg;
        if (ptaken && !ctrl) begin
            kind   = MK_FALSE_BR;
            fix_pc = pc + PC_W'(INST_BYTES);
        end else if (checked && (target != ptarg)) begin
            kind   = MK_TARGET;
            fix_pc = target;
        end
    end
endmodule

// File: rtl/dec_oldest_pick.sv
module dec_oldest_pick #(
    parameter int W = 4,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     miss,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]     keep
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (miss[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
        for (int i = 0; i < W; i++) begin
            keep[i] = !found || (IDX_W'(i) <= idx);
        end
    end
endmodule

// File: rtl/dec_redirect.sv
module dec_redirect
    import dec_redirect_pkg::*;
#(
    parameter int W          = 4,
    parameter int PC_W       = 32,
    parameter int SEQ_W      = 16,
    parameter int IMM_W      = 12,
    parameter int INST_BYTES = 4,
    parameter int FLUSH_CYC  = 1,
    parameter int CNT_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       in_valid,
    input  logic [W-1:0]       in_squashed,
    input  logic [W-1:0]       in_ctrl,
    input  logic [W-1:0]       in_direct,
    input  logic [W-1:0]       in_uncond,
    input  logic [W-1:0]       in_ptaken,
    input  logic [W*SEQ_W-1:0] in_seq,
    input  logic [W*PC_W-1:0]  in_pc,
    input  logic [W*PC_W-1:0]  in_ptarg,
    input  logic [W*IMM_W-1:0] in_imm,
    output logic [W-1:0]       out_valid,
    output logic [W*SEQ_W-1:0] out_seq,
    output logic [W*PC_W-1:0]  out_pc,
    output logic [W*PC_W-1:0]  out_ptarg,
    output logic               rd_valid,
    output logic [SEQ_W-1:0]   rd_seq,
    output logic [PC_W-1:0]    rd_npc,
    output logic               rd_taken,
    output logic               unblock,
    output logic [CNT_W-1:0]   cnt_resolved,
    output logic [CNT_W-1:0]   cnt_mispred,
    output logic [CNT_W-1:0]   cnt_ctrl_mispred
);
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
    localparam int FC_W  = $clog2(FLUSH_CYC + 1);
    localparam int RC_W  = $clog2(W + 1);

    rd_state_e        state, state_nx;
    logic [FC_W-1:0]  flush_left;
    logic [SEQ_W-1:0] bad_seq;

    logic [W-1:0]     live, miss, checked, keep, fwd;
    miss_kind_e       kind  [W];
    logic [PC_W-1:0]  fix_pc[W];
    logic [SEQ_W-1:0] seq_s [W];
    logic             found;
    logic [IDX_W-1:0] idx;
    logic [RC_W-1:0]  n_resolved;

    for (genvar g = 0; g < W; g++) begin : g_slot
        assign seq_s[g] = in_seq[g*SEQ_W +: SEQ_W];

        dec_slot_check #(.PC_W(PC_W), .IMM_W(IMM_W), .INST_BYTES(INST_BYTES)) u_chk (
            .pc     (in_pc[g*PC_W +: PC_W]),
            .imm    (in_imm[g*IMM_W +: IMM_W]),
            .ctrl   (in_ctrl[g]),
            .direct (in_direct[g]),
            .uncond (in_uncond[g]),
            .ptaken (in_ptaken[g]),
            .ptarg  (in_ptarg[g*PC_W +: PC_W]),
            .checked(checked[g]),
            .kind   (kind[g]),
            .fix_pc (fix_pc[g])
        );

        assign live[g] = in_valid[g] && !in_squashed[g] &&
                         !((state == ST_FLUSH) && (seq_s[g] > bad_seq));
        assign miss[g] = live[g] && (kind[g] != MK_NONE);
    end

    dec_oldest_pick #(.W(W)) u_pick (
        .miss (miss),
        .found(found),
        .idx  (idx),
        .keep (keep)
    );

    assign fwd = live & keep;

    always_comb begin
        n_resolved = '0;
        for (int i = 0; i < W; i++) begin
            n_resolved = n_resolved + RC_W'(fwd[i] & checked[i]);
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (found) state_nx = ST_FLUSH;
            ST_FLUSH: if (!found && flush_left == FC_W'(1)) state_nx = ST_RUN;
            default:  state_nx = ST_RUN;
        endcase
    end

    // State register, window counter and offender sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            flush_left <= '0;
            bad_seq    <= '0;
        end else begin
            state <= state_nx;
            if (found) begin
                flush_left <= FC_W'(FLUSH_CYC);
                bad_seq    <= seq_s[idx];
            end else if (state == ST_FLUSH) begin
                flush_left <= flush_left - FC_W'(1);
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid        <= '0;
            out_seq          <= '0;
            out_pc           <= '0;
            out_ptarg        <= '0;
            rd_valid         <= 1'b0;
            rd_seq           <= '0;
            rd_npc           <= '0;
            rd_taken         <= 1'b0;
            unblock          <= 1'b0;
            cnt_resolved     <= '0;
            cnt_mispred      <= '0;
            cnt_ctrl_mispred <= '0;
        end else begin
            out_valid <= fwd;
            out_seq   <= in_seq;
            out_pc    <= in_pc;
            for (int i = 0; i < W; i++) begin
                out_ptarg[i*PC_W +: PC_W] <= (found && IDX_W'(i) == idx) ?
                                             fix_pc[i] : in_ptarg[i*PC_W +: PC_W];
            end
            rd_valid     <= found;
            rd_seq       <= found ? seq_s[idx] : '0;
            rd_npc       <= found ? fix_pc[idx] : '0;
            rd_taken     <= found && (kind[idx] == MK_TARGET) &&
                            (in_ptaken[idx] || in_uncond[idx]);
            unblock      <= (state == ST_FLUSH) && (state_nx == ST_RUN);
            cnt_resolved <= cnt_resolved + CNT_W'(n_resolved);
            if (found && kind[idx] == MK_TARGET)
                cnt_mispred <= cnt_mispred + CNT_W'(1);
            if (found && kind[idx] == MK_FALSE_BR)
                cnt_ctrl_mispred <= cnt_ctrl_mispred + CNT_W'(1);
        end
    end
endmodule

// File: rtl/dec_redirect_chk.sv
module dec_redirect_chk #(
    parameter int W     = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     out_valid,
    input logic             rd_valid,
    input logic             rd_taken,
    input logic             unblock,
    input logic [CNT_W-1:0] cnt_mispred,
    input logic [CNT_W-1:0] cnt_ctrl_mispred
);
    logic [CNT_W-1:0] miss_sum;
    assign miss_sum = cnt_mispred + cnt_ctrl_mispred;

    a_r9_unblock_single: assert property (@(posedge clk) disable iff (!rst_n)
        unblock |=> !unblock);

    a_r6_offender_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (out_valid != '0));

    a_r3_false_branch_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_taken) |-> (cnt_ctrl_mispred == $past(cnt_ctrl_mispred) + CNT_W'(1)));

    a_r4_target_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_taken) |-> (cnt_mispred == $past(cnt_mispred) + CNT_W'(1)));

    a_r7_count_needs_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(miss_sum));
endmodule

bind dec_redirect dec_redirect_chk #(.W(W), .CNT_W(CNT_W)) u_dec_redirect_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .out_valid       (out_valid),
    .rd_valid        (rd_valid),
    .rd_taken        (rd_taken),
    .unblock         (unblock),
    .cnt_mispred     (cnt_mispred),
    .cnt_ctrl_mispred(cnt_ctrl_mispred)
);

// File: tb/dec_redirect_bench.sv
`timescale 1ns/1ps
module dec_redirect_bench;
    localparam int W = 4, PC_W = 32, SEQ_W = 16, IMM_W = 12, CNT_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] in_valid, in_squashed, in_ctrl, in_direct, in_uncond, in_ptaken;
    logic [W*SEQ_W-1:0] in_seq;
    logic [W*PC_W-1:0] in_pc, in_ptarg;
    logic [W*IMM_W-1:0] in_imm;
    logic [W-1:0] out_valid;
    logic [W*SEQ_W-1:0] out_seq;
    logic [W*PC_W-1:0] out_pc, out_ptarg;
    logic rd_valid, rd_taken, unblock;
    logic [SEQ_W-1:0] rd_seq;
    logic [PC_W-1:0] rd_npc;
    logic [CNT_W-1:0] cnt_resolved, cnt_mispred, cnt_ctrl_mispred;

    dec_redirect u_dec_redirect (.*);

    int n_tests = 0, n_fail = 0;
    int e_res = 0, e_mis = 0, e_ctl = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Slot kinds: 0 empty, 1 plain, 2 false branch, 3 direct ok, 4 uncond wrong,
    // 5 cond predicted-taken wrong (negative offset), 6 indirect, 7 squashed false branch
    task automatic set_slot(input int i, input int k, input logic [PC_W-1:0] pc,
                            input logic [SEQ_W-1:0] seq);
        in_valid[i]    = (k != 0);
        in_squashed[i] = (k == 7);
        in_ctrl[i]     = (k >= 3 && k <= 6);
        in_direct[i]   = (k >= 3 && k <= 5);
        in_uncond[i]   = (k == 3 || k == 4);
        in_ptaken[i]   = (k == 2 || k == 5 || k == 6 || k == 7);
        in_seq[i*SEQ_W +: SEQ_W] = seq;
        in_pc[i*PC_W +: PC_W]    = pc;
        in_imm[i*IMM_W +: IMM_W] = (k == 3 || k == 4) ? 12'h040 : (k == 5) ? 12'hFE0 : 12'h010;
        in_ptarg[i*PC_W +: PC_W] = (k == 3) ? pc + 32'h40 : (k == 4) ? pc + 32'h8 :
                                   (k == 5) ? pc + 32'h4  : (k == 6) ? pc + 32'h300 :
                                   (k == 2 || k == 7) ? pc + 32'h80 : 32'h0;
    endtask

    task automatic idle();
        for (int i = 0; i < W; i++) set_slot(i, 0, '0, '0);
    endtask

    // {k3,k2,k1,k0, expected forward mask, expected redirect slot (4 = none)}
    localparam logic [18:0] VEC [12] = '{
        {3'd1,3'd1,3'd1,3'd1, 4'b1111, 3'd4},
        {3'd1,3'd1,3'd2,3'd1, 4'b0011, 3'd1},
        {3'd1,3'd1,3'd1,3'd4, 4'b0001, 3'd0},
        {3'd1,3'd6,3'd3,3'd3, 4'b1111, 3'd4},
        {3'd3,3'd1,3'd2,3'd7, 4'b0010, 3'd1},
        {3'd5,3'd1,3'd1,3'd1, 4'b1111, 3'd3},
        {3'd0,3'd0,3'd0,3'd0, 4'b0000, 3'd4},
        {3'd1,3'd4,3'd5,3'd3, 4'b0011, 3'd1},
        {3'd7,3'd7,3'd7,3'd7, 4'b0000, 3'd4},
        {3'd2,3'd0,3'd3,3'd0, 4'b1010, 3'd3},
        {3'd0,3'd1,3'd6,3'd6, 4'b0111, 3'd4},
        {3'd3,3'd5,3'd4,3'd2, 4'b0001, 3'd0}
    };

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 0 && !rd_valid && !unblock, "R1 outputs", out_valid, 0);
        chk(cnt_resolved == 0 && cnt_mispred == 0 && cnt_ctrl_mispred == 0, "R1 counters",
            cnt_resolved, 0);
        rst_n = 1'b1;

        for (int v = 0; v < 12; v++) begin
            int k[4];
            int rs;
            logic [PC_W-1:0] base;
            for (int i = 0; i < W; i++) begin
                k[i] = int'(VEC[v][7 + 3*i +: 3]);
                set_slot(i, k[i], 32'h1000 + 32'h100 * v + 4 * i, SEQ_W'(10 * v + i + 1));
            end
            base = 32'h1000 + 32'h100 * v;
            rs = int'(VEC[v][2:0]);
            for (int i = 0; i < W; i++)
                if (VEC[v][3 + i] && k[i] >= 3 && k[i] <= 5) e_res++;
            @(negedge clk);
            // R2 R6 R7: forward mask after one cycle
            chk(out_valid == VEC[v][6:3], "R6 R2 forward mask", out_valid, VEC[v][6:3]);
            chk(rd_valid == (rs != 4), "R7 redirect presence", rd_valid, rs != 4);
            if (rs != 4) begin
                logic [PC_W-1:0] pc, npc;
                pc  = base + 4 * rs;
                npc = (k[rs] == 2) ? pc + 4 : (k[rs] == 4) ? pc + 32'h40 : pc - 32'h20;
                if (k[rs] == 2) e_ctl++; else e_mis++;
                chk(rd_seq == SEQ_W'(10 * v + rs + 1), "R7 rd_seq", rd_seq, 10 * v + rs + 1);
                chk(rd_npc == npc, (k[rs] == 2) ? "R3 next pc" : "R4 target", rd_npc, npc);
                chk(rd_taken == (k[rs] != 2), (k[rs] == 2) ? "R3 taken" : "R4 taken",
                    rd_taken, k[rs] != 2);
                chk(out_ptarg[rs*PC_W +: PC_W] == npc, "R6 corrected ptarg",
                    out_ptarg[rs*PC_W +: PC_W], npc);
            end
            chk(cnt_resolved == CNT_W'(e_res), "R10 cnt_resolved", cnt_resolved, e_res);
            chk(cnt_mispred == CNT_W'(e_mis), "R4 cnt_mispred", cnt_mispred, e_mis);
            chk(cnt_ctrl_mispred == CNT_W'(e_ctl), "R3 cnt_ctrl_mispred", cnt_ctrl_mispred, e_ctl);
            idle();
            @(negedge clk);
            chk(unblock == (rs != 4), "R9 unblock after window", unblock, rs != 4);
        end

        // R8: flush window drops younger tokens, passes older ones
        set_slot(0, 4, 32'h8000, 16'd500);
        for (int i = 1; i < W; i++) set_slot(i, 0, '0, '0);
        @(negedge clk);
        chk(rd_valid && rd_seq == 16'd500, "R8 redirect setup", rd_seq, 500);
        set_slot(0, 1, 32'h9000, 16'd499);
        set_slot(1, 1, 32'h9004, 16'd501);
        set_slot(2, 2, 32'h9008, 16'd600);
        set_slot(3, 0, '0, '0);
        @(negedge clk);
        chk(out_valid == 4'b0001, "R8 younger dropped", out_valid, 1);
        chk(!rd_valid, "R8 no redirect from dropped", rd_valid, 0);
        chk(unblock, "R9 unblock rises", unblock, 1);
        idle();
        @(negedge clk);
        chk(!unblock, "R9 unblock one cycle", unblock, 0);

        // R5: indirect with wrong target, in first slot alone
        set_slot(0, 6, 32'hA000, 16'd700);
        @(negedge clk);
        chk(out_valid == 4'b0001 && !rd_valid, "R5 indirect unchecked", rd_valid, 0);
        idle();
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule